// File: doc/BRIEF.md
# Oscillator Start-up Timer

This block holds off use of the main crystal oscillator until it has had time to settle. Software writes one mode word that carries an enable bit and an 8-bit start-up count. The enable bit drives the oscillator-enable pin at once. A counter on the slow clock then waits eight slow-clock cycles for every unit of the count and sets a stable flag when the wait is over. Software can poll that flag or unmask it as an interrupt source.

The register side runs on the bus clock. The timer runs on the slow clock. The enable level goes into the slow domain through a two-flop synchroniser. The stable flag comes back into the bus domain through a second two-flop synchroniser. The count field is taken into the timer only at the moment the synchronised enable is first seen, so a change to the count during a wait does not alter that wait. Clearing the enable stops the oscillator, drops the stable flag and clears the counter. Setting the enable again starts a full new wait.

Top module: `osc_startup_timer`

## Requirements
- R1: A write to address 0 loads the mode word. Bit 0 is the enable, and `oscEnable` follows it from the bus cycle after the write. Bits 15:8 are the start-up count.
- R2: After reset, `oscEnable`, `stableStatus` and `irqOut` are all 0 and the interrupt mask is clear.
- R3: With a count N, the stable flag is set on slow-clock rising edge number 8·N+3 after the enabling write. This figure counts two edges of enable synchronisation and one start edge. `stableStatus` shows the flag within two bus cycles of that edge, and the counter never runs past its target.
- R4: The mode value 0x00000701 gives a 56-cycle wait, so the flag is set on slow edge 59 after the write.
- R5: A count of 0 sets the stable flag on the first slow edge at which the synchronised enable is seen, which is slow edge 3 after the write.
- R6: Writing enable 0 drives `oscEnable` low on the next bus cycle. The stable flag and `stableStatus` are clear no later than slow edge 4 after that write, and the counter is cleared.
- R7: Setting the enable again after a disable, including a disable in the middle of a wait, runs the full 8·N wait from the start.
- R8: Writing 1 to bit 0 at address 1 unmasks the interrupt, and writing 1 to bit 0 at address 2 masks it. A 0 in bit 0 at either address has no effect. `irqOut` is the synchronised stable flag ANDed with the mask.
- R9: A new count written while the enable stays at 1 does not change the wait already in progress.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| busClk | input | 1 | Register-interface clock |
| rstN | input | 1 | Asynchronous active-low reset for both domains |
| slowClk | input | 1 | Slow clock that times the start-up wait |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 2 | Register address: 0 mode, 1 interrupt unmask, 2 interrupt mask |
| wrData | input | 32 | Register write data |
| oscEnable | output | 1 | Enable to the analog oscillator |
| stableStatus | output | 1 | Stable flag, synchronised to busClk |
| irqOut | output | 1 | Interrupt request: stable flag and mask |

## Verification
The assertions check the local rules on every clock edge. They check that a mode write shows up on the enable, that the unmask and mask writes take effect, that the tick counter stays within its target, that the strobes to the counter are exclusive, that a zero count sets the flag at once, and that the done state is left as soon as the synchronised enable drops. The end-to-end latency in slow edges crosses both clock domains, so only the bench scenarios can show it. The same holds for the restart after an aborted wait, for a count rewritten during a wait being ignored, and for the interrupt pin following the stable flag. The bench measures each of these against the latency formula it computes itself.

// File: rtl/osc_timer_pkg.sv
package osc_timer_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_COUNT = 2'd1,
    ST_DONE  = 2'd2
  } oscState_e;

  // Strobes from the slow-domain control to the tick datapath
  typedef struct packed {
    logic loadCnt;
    logic incCnt;
    logic clrCnt;
    logic setStable;
    logic clrStable;
  } cntStrobes_t;

endpackage

// File: rtl/osc_timer_sync.sv
module osc_timer_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic d,
  output logic q
);

  logic [STAGES-1:0] ff;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) ff <= '0;
        else       ff <= d;
      end
    end else begin : g_chain
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) ff <= '0;
        else       ff <= {ff[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = ff[STAGES-1];

endmodule

// File: rtl/osc_timer_regs.sv
module osc_timer_regs #(
  parameter int ADDR_W  = 2,
  parameter int DATA_W  = 32,
  parameter int CNT_W   = 8,
  parameter int CNT_LSB = 8,
  parameter int EN_BIT  = 0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              stableSync,
  output logic              modeEnable,
  output logic [CNT_W-1:0]  modeCount,
  output logic              irqOut
);

  localparam logic [ADDR_W-1:0] MODE_ADDR    = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] IRQ_SET_ADDR = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] IRQ_CLR_ADDR = ADDR_W'(2);

  logic irqMask;
  logic modeWr, setWr, clrWr;
  logic unusedData;

  assign modeWr = wrEn && (wrAddr == MODE_ADDR);
  assign setWr  = wrEn && (wrAddr == IRQ_SET_ADDR) && wrData[0];
  assign clrWr  = wrEn && (wrAddr == IRQ_CLR_ADDR) && wrData[0];
  assign unusedData = ^wrData;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeEnable <= 1'b0;
      modeCount  <= '0;
    end else if (modeWr) begin
      modeEnable <= wrData[EN_BIT];
      modeCount  <= wrData[CNT_LSB +: CNT_W];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)      irqMask <= 1'b0;
    else if (setWr) irqMask <= 1'b1;
    else if (clrWr) irqMask <= 1'b0;
  end

  assign irqOut = stableSync && irqMask;

  p_enable_write_r1: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrAddr == MODE_ADDR) |=> (modeEnable == $past(wrData[EN_BIT])));

  p_mask_set_r8: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrAddr == IRQ_SET_ADDR && wrData[0]) |=> irqMask);

  p_mask_clr_r8: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrAddr == IRQ_CLR_ADDR && wrData[0]) |=> !irqMask);

  p_mask_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    !(wrEn && (wrAddr == IRQ_SET_ADDR || wrAddr == IRQ_CLR_ADDR) && wrData[0])
      |=> $stable(irqMask));

endmodule

// File: rtl/osc_timer_ctrl.sv
module osc_timer_ctrl
  import osc_timer_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        enSlow,
  input  logic        zeroReq,
  input  logic        lastTick,
  output cntStrobes_t str
);

  oscState_e state, stateNext;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    stateNext = state;
    str       = '0;
    case (state)
      ST_IDLE: begin
        if (enSlow) begin
          str.loadCnt = 1'b1;
          if (zeroReq) begin
            str.setStable = 1'b1;
            stateNext     = ST_DONE;
          end else begin
            stateNext = ST_COUNT;
          end
        end
      end
      ST_COUNT: begin
        if (!enSlow) begin
          str.clrCnt    = 1'b1;
          str.clrStable = 1'b1;
          stateNext     = ST_IDLE;
        end else if (lastTick) begin
          str.setStable = 1'b1;
          stateNext     = ST_DONE;
        end else begin
          str.incCnt = 1'b1;
        end
      end
      ST_DONE: begin
        if (!enSlow) begin
          str.clrCnt    = 1'b1;
          str.clrStable = 1'b1;
          stateNext     = ST_IDLE;
        end
      end
      default: begin
        str.clrCnt    = 1'b1;
        str.clrStable = 1'b1;
        stateNext     = ST_IDLE;
      end
    endcase
  end

  p_strobe_excl_r3: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({str.loadCnt, str.incCnt, str.clrCnt}));

  p_done_left_r6: assert property (@(posedge clk) disable iff (!rstN)
    !enSlow |=> (state != ST_DONE));

endmodule

// File: rtl/osc_timer_dp.sv
module osc_timer_dp
  import osc_timer_pkg::*;
#(
  parameter int CNT_W       = 8,
  parameter int SCALE_SHIFT = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  cntStrobes_t      str,
  input  logic [CNT_W-1:0] countIn,
  output logic             zeroReq,
  output logic             lastTick,
  output logic             stableFlag
);

  localparam int TICK_W = CNT_W + SCALE_SHIFT;

  logic [TICK_W-1:0] tickCnt;
  logic [TICK_W-1:0] targetReg;

  // countIn crosses from the bus domain; it is sampled only on loadCnt,
  // which comes two slow edges after the enable write, so it has settled.
  assign zeroReq  = (countIn == '0);
  assign lastTick = (tickCnt == TICK_W'(targetReg - 1'b1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tickCnt   <= '0;
      targetReg <= '0;
    end else if (str.loadCnt) begin
      tickCnt   <= '0;
      targetReg <= {countIn, {SCALE_SHIFT{1'b0}}};
    end else if (str.clrCnt) begin
      tickCnt <= '0;
    end else if (str.incCnt) begin
      tickCnt <= tickCnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              stableFlag <= 1'b0;
    else if (str.clrStable) stableFlag <= 1'b0;
    else if (str.setStable) stableFlag <= 1'b1;
  end

  p_cnt_bound_r3: assert property (@(posedge clk) disable iff (!rstN)
    tickCnt <= targetReg);

  p_zero_fast_r5: assert property (@(posedge clk) disable iff (!rstN)
    (str.loadCnt && zeroReq) |=> stableFlag);

  p_stable_clears_r6: assert property (@(posedge clk) disable iff (!rstN)
    str.clrStable |=> !stableFlag);

endmodule

// File: rtl/osc_startup_timer.sv
module osc_startup_timer
  import osc_timer_pkg::*;
#(
  parameter int ADDR_W      = 2,
  parameter int DATA_W      = 32,
  parameter int CNT_W       = 8,
  parameter int CNT_LSB     = 8,
  parameter int EN_BIT      = 0,
  parameter int SCALE_SHIFT = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic              busClk,
  input  logic              rstN,
  input  logic              slowClk,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  output logic              oscEnable,
  output logic              stableStatus,
  output logic              irqOut
);

  logic             modeEnable;
  logic [CNT_W-1:0] modeCount;
  logic             enSlow;
  logic             zeroReq;
  logic             lastTick;
  logic             stableFlag;
  cntStrobes_t      str;

  osc_timer_regs #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W),
    .CNT_LSB(CNT_LSB), .EN_BIT(EN_BIT)
  ) u_regs (
    .clk(busClk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr),
    .wrData(wrData), .stableSync(stableStatus),
    .modeEnable(modeEnable), .modeCount(modeCount), .irqOut(irqOut)
  );

  osc_timer_sync #(.STAGES(SYNC_STAGES)) u_enSync (
    .clk(slowClk), .rstN(rstN), .d(modeEnable), .q(enSlow)
  );

  osc_timer_ctrl u_ctrl (
    .clk(slowClk), .rstN(rstN), .enSlow(enSlow),
    .zeroReq(zeroReq), .lastTick(lastTick), .str(str)
  );

  osc_timer_dp #(.CNT_W(CNT_W), .SCALE_SHIFT(SCALE_SHIFT)) u_dp (
    .clk(slowClk), .rstN(rstN), .str(str), .countIn(modeCount),
    .zeroReq(zeroReq), .lastTick(lastTick), .stableFlag(stableFlag)
  );

  osc_timer_sync #(.STAGES(SYNC_STAGES)) u_stableSync (
    .clk(busClk), .rstN(rstN), .d(stableFlag), .q(stableStatus)
  );

  assign oscEnable = modeEnable;

endmodule

// File: tb/osc_startup_timer_tb.sv
module osc_startup_timer_tb;

  logic        busClk = 1'b0;
  logic        slowClk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [1:0]  wrAddr = '0;
  logic [31:0] wrData = '0;
  logic        oscEnable, stableStatus, irqOut;

  int checks = 0;
  int errors = 0;
  int issued = 0;
  int doneCnt = 0;

  typedef struct {
    int    expLat;
    string tag;
  } item_t;
  item_t expQ[$];

  always #10 busClk = ~busClk;           // 50 MHz
  initial begin
    #5;
    forever #100 slowClk = ~slowClk;     // rising edges at 105, 305, ...
  end

  osc_startup_timer u_dut (
    .busClk(busClk), .rstN(rstN), .slowClk(slowClk),
    .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .oscEnable(oscEnable), .stableStatus(stableStatus), .irqOut(irqOut)
  );

  task automatic check(input int actual, input int expected, input string tag);
    checks++;
    if (actual != expected) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, actual, expected);
    end
  endtask

  task automatic writeReg(input logic [1:0] addr, input logic [31:0] data);
    @(negedge busClk);
    wrEn = 1'b1; wrAddr = addr; wrData = data;
    @(posedge busClk);
    #1;
    wrEn = 1'b0; wrData = '0;
  endtask

  function automatic logic [31:0] modeWord(input int count, input bit en);
    return {16'h0, 8'(count), 7'h0, en};
  endfunction

  // Driver: write mode, push expected latency in slow edges
  task automatic startOsc(input int count, input string tag);
    writeReg(2'd0, modeWord(count, 1'b1));
    expQ.push_back('{count * 8 + 3, tag});
    issued++;
  endtask

  task automatic waitDone();
    wait (doneCnt == issued);
    @(negedge busClk);
  endtask

  task automatic stopOsc(input string tag);
    writeReg(2'd0, 32'h0);
    check(oscEnable, 0, {tag, " oscEnable low"});
    repeat (4) @(posedge slowClk);
    #100;
    check(stableStatus, 0, {tag, " stable cleared"});
    check(irqOut, 0, {tag, " irq cleared"});
  endtask

  // Monitor: measure slow edges until stableStatus rises
  initial begin
    forever begin
      item_t it;
      int n;
      wait (expQ.size() > 0);
      it = expQ[0];
      n = 0;
      while (n < 2200) begin
        @(posedge slowClk);
        n++;
        #100;
        if (stableStatus) break;
      end
      void'(expQ.pop_front());
      check(n, it.expLat, {it.tag, " start-up latency"});
      doneCnt++;
    end
  end

  initial begin
    repeat (190000) @(posedge busClk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge busClk);
    rstN = 1'b1;
    @(negedge busClk);
    check(oscEnable, 0, "R2 oscEnable reset");
    check(stableStatus, 0, "R2 stable reset");
    check(irqOut, 0, "R2 irq reset");

    // R4 / R1: 0x701 -> 56 cycles, 59 slow edges from write
    writeReg(2'd0, 32'h0000_0701);
    expQ.push_back('{59, "R4"});
    issued++;
    check(oscEnable, 1, "R1 enable follows write");
    waitDone();

    // R8 mask behaviour
    check(irqOut, 0, "R8 masked irq");
    writeReg(2'd1, 32'h0);
    check(irqOut, 0, "R8 zero unmask write ignored");
    writeReg(2'd1, 32'h1);
    check(irqOut, 1, "R8 unmask raises irq");
    writeReg(2'd2, 32'h0);
    check(irqOut, 1, "R8 zero mask write ignored");
    writeReg(2'd2, 32'h1);
    check(irqOut, 0, "R8 mask drops irq");
    writeReg(2'd1, 32'h1);
    check(irqOut, 1, "R8 unmask again");

    stopOsc("R6");

    // R5: zero count
    startOsc(0, "R5");
    waitDone();
    check(irqOut, 1, "R8 irq follows stable");
    stopOsc("R6 after zero");

    // R3: small count
    startOsc(2, "R3");
    waitDone();
    stopOsc("R6 after R3");

    // R7: abort mid-wait, then full restart
    writeReg(2'd0, modeWord(10, 1'b1));
    repeat (30) @(posedge slowClk);
    #100;
    check(stableStatus, 0, "R7 not stable mid-wait");
    stopOsc("R7 abort");
    startOsc(10, "R7");
    waitDone();
    stopOsc("R6 after R7");

    // R9: count rewritten during wait is ignored
    startOsc(20, "R9");
    repeat (5) @(posedge slowClk);
    writeReg(2'd0, modeWord(2, 1'b1));
    check(oscEnable, 1, "R9 enable kept");
    waitDone();
    stopOsc("R6 after R9");

    // R3: maximum count
    startOsc(255, "R3 max");
    waitDone();
    stopOsc("R6 after max");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule